// File: doc/BRIEF.md
# Four-Context Thread Picker

An in-order core that runs four hardware thread contexts has to choose, on every cycle, the one context it will fetch and issue from. This block makes that choice. It takes a per-context active mask and a per-context load-miss report, and it returns a one-hot grant with a valid flag. A context that was granted in one cycle cannot be chosen in the next cycle. A single running thread therefore issues at most every other cycle, and the pipeline is kept full by interleaving several threads.

A context that reports a load miss leaves the eligible set from the following cycle until its fill-complete strobe has been seen. The other contexts keep issuing throughout. Misses that are not loads, such as store misses, are reported on the same strobe with the load flag low and do not affect eligibility. Among the contexts that are eligible, the picker goes round-robin, starting with the index just after the last granted one.

Top module: `thr_picker`

## Requirements
- R1: While rst_ni is low, grant_o is zero and valid_o is low. After reset releases with all contexts active, the first grant is context 0 (grant_o = 4'b0001). Bit k of every vector belongs to context k.
- R2: grant_o is zero or one-hot. valid_o is high exactly when grant_o is non-zero. A granted context has its active_i bit high, is not suspended, and was not granted in the previous cycle.
- R3: A context granted in cycle N is not granted in cycle N+1.
- R4: When exactly one context is active and it is never suspended, that context is granted in exactly half of any run of an even number of cycles, on alternate cycles.
- R5: The picker grants the first eligible context found by scanning upward from the last granted index plus one, wrapping from 3 to 0.
- R6: A load miss (miss_vld_i[k] and miss_ld_i[k] both high in cycle N) keeps context k from being granted from cycle N+1. Context k becomes eligible again in the cycle after fill_i[k] is high with no new load miss.
- R7: A miss with miss_ld_i[k] low (a store or other non-load miss) does not change whether context k can be granted.
- R8: When fill_i[k] and a new load miss for context k are high in the same cycle, context k stays suspended.
- R9: When no context is eligible, valid_o is low, grant_o is zero, and in the next cycle no context is excluded for having issued previously.
- R10: While one context is suspended, the remaining active contexts continue to receive grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 4 | Context holds a runnable thread |
| miss_vld_i | input | 4 | Miss reported by the context this cycle |
| miss_ld_i | input | 4 | The reported miss is a load miss |
| fill_i | input | 4 | The outstanding load fill for the context has completed |
| grant_o | output | 4 | One-hot issue grant |
| valid_o | output | 1 | A context is granted this cycle |

## Verification
The properties assume that the miss, load-type and fill strobes are synchronous single-cycle indications. They also assume that a fill only arrives for a context that has a load miss outstanding, although a stray fill does no harm because it only clears an already clear suspension. The stimulus changes inputs only on the falling clock edge. Its random phase raises fill only for contexts that the bench model holds suspended. It also covers the case where a fill and a new load miss for the same context arrive in the same cycle, which is the one case where two inputs act on the same suspension bit.

// File: rtl/thr_pick_pkg.sv
package thr_pick_pkg;
  localparam int unsigned N_CTX_DEF = 4;
endpackage

// File: rtl/thr_pick_susp.sv
module thr_pick_susp #(
  parameter int unsigned N_CTX = thr_pick_pkg::N_CTX_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CTX-1:0] miss_vld_i,
  input  logic [N_CTX-1:0] miss_ld_i,
  input  logic [N_CTX-1:0] fill_i,
  output logic [N_CTX-1:0] susp_o
);
  logic [N_CTX-1:0] susp_q;

  for (genvar k = 0; k < N_CTX; k++) begin : g_ctx
    logic ld_miss;
    assign ld_miss = miss_vld_i[k] & miss_ld_i[k];
    // new miss wins over a simultaneous fill
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        susp_q[k] <= 1'b0;
      else if (ld_miss)   susp_q[k] <= 1'b1;
      else if (fill_i[k]) susp_q[k] <= 1'b0;
    end
  end

  assign susp_o = susp_q;
endmodule

// File: rtl/thr_pick_hist.sv
module thr_pick_hist #(
  parameter int unsigned N_CTX = thr_pick_pkg::N_CTX_DEF,
  localparam int unsigned IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [N_CTX-1:0] gnt_i,
  input  logic [IDX_W-1:0] gnt_idx_i,
  output logic [N_CTX-1:0] last_o,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(N_CTX - 1);

  logic [N_CTX-1:0] last_q;
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      ptr_q  <= PTR_RST;
    end else if (vld_i) begin
      last_q <= gnt_i;
      ptr_q  <= gnt_idx_i;
    end else begin
      last_q <= '0;  // idle cycle lifts the exclusion
    end
  end

  assign last_o = last_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/thr_pick_arb.sv
module thr_pick_arb #(
  parameter int unsigned N_CTX = thr_pick_pkg::N_CTX_DEF,
  localparam int unsigned IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             en_i,
  input  logic [N_CTX-1:0] active_i,
  input  logic [N_CTX-1:0] susp_i,
  input  logic [N_CTX-1:0] last_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_CTX-1:0] gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             vld_o
);
  logic [N_CTX-1:0] elig;
  logic             found;
  int unsigned      cand;

  assign elig  = en_i ? (active_i & ~susp_i & ~last_i) : '0;
  assign vld_o = |elig;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    cand      = 0;
    for (int unsigned i = 1; i <= N_CTX; i++) begin
      cand = (int'(ptr_i) + i) % N_CTX;
      if (!found && elig[cand]) begin
        gnt_o[cand] = 1'b1;
        gnt_idx_o   = cand[IDX_W-1:0];
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/thr_picker.sv
module thr_picker #(
  parameter int unsigned N_CTX = thr_pick_pkg::N_CTX_DEF,
  localparam int unsigned IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CTX-1:0] active_i,
  input  logic [N_CTX-1:0] miss_vld_i,
  input  logic [N_CTX-1:0] miss_ld_i,
  input  logic [N_CTX-1:0] fill_i,
  output logic [N_CTX-1:0] grant_o,
  output logic             valid_o
);
  logic [N_CTX-1:0] susp, last, gnt;
  logic [IDX_W-1:0] ptr, gnt_idx;
  logic             vld;

  thr_pick_susp #(.N_CTX(N_CTX)) i_susp (
    .clk_i, .rst_ni, .miss_vld_i, .miss_ld_i, .fill_i, .susp_o(susp)
  );

  thr_pick_arb #(.N_CTX(N_CTX)) i_arb (
    .en_i(rst_ni), .active_i, .susp_i(susp), .last_i(last), .ptr_i(ptr),
    .gnt_o(gnt), .gnt_idx_o(gnt_idx), .vld_o(vld)
  );

  thr_pick_hist #(.N_CTX(N_CTX)) i_hist (
    .clk_i, .rst_ni, .vld_i(vld), .gnt_i(gnt), .gnt_idx_i(gnt_idx),
    .last_o(last), .ptr_o(ptr)
  );

  assign grant_o = gnt;
  assign valid_o = vld;
endmodule

// File: rtl/thr_picker_chk.sv
module thr_picker_chk #(
  parameter int unsigned N_CTX = thr_pick_pkg::N_CTX_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CTX-1:0] active_i,
  input logic [N_CTX-1:0] miss_vld_i,
  input logic [N_CTX-1:0] miss_ld_i,
  input logic [N_CTX-1:0] grant_o,
  input logic             valid_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (grant_o == '0 && !valid_o));
  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant_o));
  // R2
  valid_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o == (grant_o != '0));
  // R2
  grant_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_o & ~active_i) == '0);
  // R3
  no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_o & $past(grant_o)) == '0);
  // R6
  miss_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & $past(miss_vld_i & miss_ld_i)) == '0);
endmodule

bind thr_picker thr_picker_chk #(.N_CTX(N_CTX)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i), .miss_vld_i(miss_vld_i),
  .miss_ld_i(miss_ld_i), .grant_o(grant_o), .valid_o(valid_o)
);

// File: tb/test_thr_picker.sv
module test_thr_picker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] active_i = '0, miss_vld_i = '0, miss_ld_i = '0, fill_i = '0;
  logic [3:0] grant_o;
  logic       valid_o;

  int checks = 0, errors = 0;
  bit done = 0;
  // reference state
  bit m_susp[4];
  int m_last = -1;
  int m_ptr = 3;
  logic [3:0] obs;

  always #5ns clk_i = ~clk_i;

  thr_picker i_thr_picker (.*);

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic int pick();
    for (int i = 1; i <= 4; i++) begin
      int c = (m_ptr + i) % 4;
      if (active_i[c] && !m_susp[c] && c != m_last) return c;
    end
    return -1;
  endfunction

  // caller sets inputs just after a falling edge; compares, then advances one clock
  task automatic tick(input string tag);
    int p;
    logic [3:0] e;
    #1ns;
    p = pick();
    e = (p >= 0) ? (4'b1 << p) : 4'b0;
    obs = grant_o;
    chk(grant_o == e && valid_o == (p >= 0), tag, grant_o, e);
    if (p >= 0) begin m_last = p; m_ptr = p; end else m_last = -1;
    for (int k = 0; k < 4; k++) begin
      if (miss_vld_i[k] && miss_ld_i[k]) m_susp[k] = 1;
      else if (fill_i[k]) m_susp[k] = 0;
    end
    @(negedge clk_i);
    miss_vld_i = '0; miss_ld_i = '0; fill_i = '0;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt, other;
    bit seen;
    for (int k = 0; k < 4; k++) m_susp[k] = 0;
    active_i = 4'hF;
    @(negedge clk_i);
    #1ns;
    chk(grant_o == 0 && !valid_o, "R1 reset", grant_o, 4'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick("R1");
    chk(obs == 4'b0001, "R1 first grant", obs, 4'b0001);
    for (int i = 0; i < 8; i++) tick("R5");

    // R4: single context
    active_i = 4'b0100; cnt = 0;
    for (int i = 0; i < 8; i++) begin tick("R4"); if (obs[2]) cnt++; end
    chk(cnt == 4, "R4 half rate", 4'(cnt), 4'd4);

    // R6 / R10: load miss on context 1
    active_i = 4'hF;
    tick("R5");
    miss_vld_i = 4'b0010; miss_ld_i = 4'b0010;
    tick("R6");
    seen = 0; other = 0;
    for (int i = 0; i < 6; i++) begin tick("R6"); if (obs[1]) seen = 1; if (obs != 0) other++; end
    chk(!seen, "R6 suspended", {3'b0, seen}, 4'b0);
    chk(other == 6, "R10 others issue", 4'(other), 4'd6);
    fill_i = 4'b0010;
    tick("R6");
    seen = 0;
    for (int i = 0; i < 4; i++) begin tick("R6"); if (obs[1]) seen = 1; end
    chk(seen, "R6 resume", {3'b0, seen}, 4'b1);

    // R7: store miss on context 3
    miss_vld_i = 4'b1000; miss_ld_i = 4'b0000;
    tick("R7");
    seen = 0;
    for (int i = 0; i < 4; i++) begin tick("R7"); if (obs[3]) seen = 1; end
    chk(seen, "R7 store miss ignored", {3'b0, seen}, 4'b1);

    // R8: fill and new miss together
    miss_vld_i = 4'b0001; miss_ld_i = 4'b0001;
    tick("R8");
    tick("R8");
    fill_i = 4'b0001; miss_vld_i = 4'b0001; miss_ld_i = 4'b0001;
    tick("R8");
    seen = 0;
    for (int i = 0; i < 6; i++) begin tick("R8"); if (obs[0]) seen = 1; end
    chk(!seen, "R8 stays suspended", {3'b0, seen}, 4'b0);
    fill_i = 4'b0001;
    tick("R8");

    // R9: nothing eligible, then restriction cleared
    active_i = 4'b0000;
    tick("R9");
    chk(obs == 0 && !valid_o, "R9 idle", obs, 4'b0);
    active_i = 4'b0001;
    tick("R9");
    active_i = 4'b0000;
    tick("R9");
    active_i = 4'b0001;
    tick("R9");
    chk(obs == 4'b0001, "R9 cleared after idle", obs, 4'b0001);

    // R2 / R3: random mix
    for (int i = 0; i < 400; i++) begin
      active_i = 4'($urandom_range(0, 15));
      for (int k = 0; k < 4; k++) begin
        if ($urandom_range(0, 9) == 0) begin
          miss_vld_i[k] = 1'b1; miss_ld_i[k] = 1'($urandom_range(0, 1));
        end
        if (m_susp[k] && $urandom_range(0, 3) == 0) fill_i[k] = 1'b1;
      end
      tick("R2 R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule